// File: doc/BRIEF.md
# Power-Aware Adaptive Route Selector

This block picks the output direction and channel class for a head flit at one router of a 4x4 mesh in which any neighbouring router may be switched off to save leakage. It applies adaptive routing. A productive (distance-reducing) direction is used whenever its neighbour is powered and its output is free. A single non-productive hop is taken only when every productive neighbour is switched off. Each such hop increments a misroute count that travels in the header. Once that count reaches a programmable limit, the packet is moved onto the escape class, which runs on a ring of bypass links that stays up even while routers are off. A packet already on the escape class stays on the ring until it reaches its destination node.

The selection is registered. Inputs presented with `req_vld_i` high at a rising edge produce a result on the outputs after that edge. The outputs hold their values while no request is offered.

Top module: `power_route_sel`

## Requirements
- R1: While `rst_n` is low, the outputs are `sel_vld_o`=0, `sel_port_o`=6 (hold), `esc_o`=0 and `mis_cnt_o`=0.
- R2: `sel_vld_o` equals `req_vld_i` from the previous rising edge, and the result of that request appears in the same cycle. The port codes are 0 eject, 1 east (x+1), 2 west (x-1), 3 north (y+1), 4 south (y-1), 5 ring and 6 hold.
- R3: When the destination equals the current node, the port is eject whatever the neighbour power, output and count inputs are. `esc_o` copies `on_esc_i` and the count passes through unchanged.
- R4: When the destination differs from the current node and `on_esc_i`=1, the port is ring and `esc_o`=1. The adaptive candidates are ignored and the count is unchanged.
- R5: When the destination differs from the current node and `mis_cnt_i` >= `mis_thr_i`, the port is ring and `esc_o`=1, even if a productive port is usable.
- R6: A productive direction is usable when its bit is set in both `nbr_pwr_i` and `out_free_i` (bit 0 east, 1 west, 2 north, 3 south). If any productive direction is usable, the X one is chosen before the Y one, with `esc_o`=0 and the count unchanged.
- R7: When no productive direction is usable but at least one productive neighbour is powered, the port is hold, `esc_o`=0 and the count is unchanged.
- R8: When every productive neighbour is powered off, a non-productive direction is chosen. It must stay inside the mesh and have its neighbour powered and its output free, and the order tried is east, west, north, south. The count is output incremented by one and `esc_o`=0.
- R9: When every productive neighbour is off and no non-productive direction qualifies, the port is ring and `esc_o`=1.
- R10: A cycle with `req_vld_i` low leaves `sel_port_o`, `esc_o` and `mis_cnt_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_vld_i | input | 1 | Head flit present for routing |
| cur_x_i | input | 2 | X coordinate of this router |
| cur_y_i | input | 2 | Y coordinate of this router |
| dst_x_i | input | 2 | Destination X |
| dst_y_i | input | 2 | Destination Y |
| nbr_pwr_i | input | 4 | Neighbour powered, bit 0 E, 1 W, 2 N, 3 S |
| out_free_i | input | 4 | Output available, same bit order |
| on_esc_i | input | 1 | Packet already on the escape class |
| mis_cnt_i | input | 3 | Misroute count from the header |
| mis_thr_i | input | 3 | Misroute limit |
| sel_vld_o | output | 1 | Result valid |
| sel_port_o | output | 3 | Selected port code |
| esc_o | output | 1 | Packet uses the escape class |
| mis_cnt_o | output | 3 | Updated misroute count |

## Verification
The rules collide when a single request meets the conditions for arrival, escape and adaptive routing at once. The bench provokes this with a flit that arrives at its destination while it already sits on the escape class with its count at the limit and every neighbour off, and expects eject. It also offers a request whose count meets the limit while a productive port is free, and expects ring rather than the productive port. Each collision is judged against a reference model in the bench that applies the priority order eject, escape, limit, productive, hold, detour, ring.

// File: rtl/route_sel_pkg.sv
// Shared port codes and direction indices for the route selector.
package route_sel_pkg;
    typedef enum logic [2:0] {
        PORT_EJECT = 3'd0,
        PORT_EAST  = 3'd1,
        PORT_WEST  = 3'd2,
        PORT_NORTH = 3'd3,
        PORT_SOUTH = 3'd4,
        PORT_RING  = 3'd5,
        PORT_HOLD  = 3'd6
    } port_e;

    localparam int NDIR    = 4;
    localparam int DIR_E   = 0;
    localparam int DIR_W   = 1;
    localparam int DIR_N   = 2;
    localparam int DIR_S   = 3;
endpackage

// File: rtl/rsel_min_dirs.sv
// Productive-direction finder: marks each direction that reduces the
// distance to the destination, and flags arrival.
// Assumes unsigned coordinates with x growing east and y growing north.
module rsel_min_dirs #(
    parameter int CW = 2
) (
    input  logic [CW-1:0] cur_x,
    input  logic [CW-1:0] cur_y,
    input  logic [CW-1:0] dst_x,
    input  logic [CW-1:0] dst_y,
    output logic [3:0]    min_mask,
    output logic          at_dest
);
    import route_sel_pkg::*;

    // Sign of each coordinate difference selects the productive directions.
    always_comb begin
        min_mask        = '0;
        min_mask[DIR_E] = dst_x > cur_x;
        min_mask[DIR_W] = dst_x < cur_x;
        min_mask[DIR_N] = dst_y > cur_y;
        min_mask[DIR_S] = dst_y < cur_y;
        at_dest         = (dst_x == cur_x) && (dst_y == cur_y);
    end
endmodule

// File: rtl/rsel_detour_dirs.sv
// Detour-direction finder: marks non-productive directions whose
// neighbour lies inside the mesh. Assumes mesh size fits CW bits.
module rsel_detour_dirs #(
    parameter int MESH_X = 4,
    parameter int MESH_Y = 4,
    parameter int CW     = 2
) (
    input  logic [CW-1:0] cur_x,
    input  logic [CW-1:0] cur_y,
    input  logic [3:0]    min_mask,
    output logic [3:0]    det_mask
);
    import route_sel_pkg::*;

    localparam logic [CW-1:0] X_MAX = CW'(MESH_X - 1);
    localparam logic [CW-1:0] Y_MAX = CW'(MESH_Y - 1);

    logic [3:0] in_mesh;

    // Edge test per direction: the neighbour must exist.
    always_comb begin
        in_mesh        = '0;
        in_mesh[DIR_E] = cur_x != X_MAX;
        in_mesh[DIR_W] = cur_x != '0;
        in_mesh[DIR_N] = cur_y != Y_MAX;
        in_mesh[DIR_S] = cur_y != '0;
    end

    // Each detour candidate is an in-mesh direction that is not productive.
    for (genvar d = 0; d < NDIR; d++) begin : g_det
        assign det_mask[d] = in_mesh[d] && !min_mask[d];
    end
endmodule

// File: rtl/rsel_first_pick.sv
// Fixed-priority picker: returns the lowest set bit of a mask.
// Assumes N >= 2; index 0 has the highest priority.
module rsel_first_pick #(
    parameter int N  = 4,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/power_route_sel.sv
// Power-aware adaptive route selector for one router of a mesh.
// Chooses an output port and channel class for a head flit. Switched-off
// neighbours count as unusable, a one-hop detour is allowed only when
// every productive neighbour is off, and the header misroute count forces
// the escape ring once it reaches the limit. One registered stage.
// Assumes neighbour power and output-free inputs are valid with the request.
module power_route_sel #(
    parameter int MESH_X = 4,
    parameter int MESH_Y = 4,
    parameter int CNT_W  = 3,
    localparam int CW    = $clog2((MESH_X > MESH_Y) ? MESH_X : MESH_Y)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_vld_i,
    input  logic [CW-1:0]    cur_x_i,
    input  logic [CW-1:0]    cur_y_i,
    input  logic [CW-1:0]    dst_x_i,
    input  logic [CW-1:0]    dst_y_i,
    input  logic [3:0]       nbr_pwr_i,
    input  logic [3:0]       out_free_i,
    input  logic             on_esc_i,
    input  logic [CNT_W-1:0] mis_cnt_i,
    input  logic [CNT_W-1:0] mis_thr_i,
    output logic             sel_vld_o,
    output logic [2:0]       sel_port_o,
    output logic             esc_o,
    output logic [CNT_W-1:0] mis_cnt_o
);
    import route_sel_pkg::*;

    logic [3:0]       min_mask, det_mask, min_use, det_use;
    logic             at_dest, min_found, det_found;
    logic [1:0]       min_idx, det_idx;
    port_e            nxt_port, port_q;
    logic             nxt_esc, esc_q, vld_q;
    logic [CNT_W-1:0] nxt_cnt, cnt_q;

    rsel_min_dirs #(.CW(CW)) u_min (
        .cur_x(cur_x_i), .cur_y(cur_y_i),
        .dst_x(dst_x_i), .dst_y(dst_y_i),
        .min_mask(min_mask), .at_dest(at_dest)
    );

    rsel_detour_dirs #(.MESH_X(MESH_X), .MESH_Y(MESH_Y), .CW(CW)) u_det (
        .cur_x(cur_x_i), .cur_y(cur_y_i),
        .min_mask(min_mask), .det_mask(det_mask)
    );

    // Usable candidates need a powered neighbour and a free output.
    assign min_use = min_mask & nbr_pwr_i & out_free_i;
    assign det_use = det_mask & nbr_pwr_i & out_free_i;

    rsel_first_pick #(.N(NDIR)) u_pick_min (
        .req(min_use), .found(min_found), .idx(min_idx)
    );

    rsel_first_pick #(.N(NDIR)) u_pick_det (
        .req(det_use), .found(det_found), .idx(det_idx)
    );

    // Decision ladder: eject, escape, limit, productive, hold, detour, ring.
    always_comb begin
        nxt_port = PORT_HOLD;
        nxt_esc  = 1'b0;
        nxt_cnt  = mis_cnt_i;
        if (at_dest) begin
            nxt_port = PORT_EJECT;
            nxt_esc  = on_esc_i;
        end else if (on_esc_i || (mis_cnt_i >= mis_thr_i)) begin
            nxt_port = PORT_RING;
            nxt_esc  = 1'b1;
        end else if (min_found) begin
            nxt_port = port_e'(3'(min_idx) + 3'd1);
        end else if (|(min_mask & nbr_pwr_i)) begin
            nxt_port = PORT_HOLD;
        end else if (det_found) begin
            nxt_port = port_e'(3'(det_idx) + 3'd1);
            nxt_cnt  = CNT_W'(mis_cnt_i + 1'b1);
        end else begin
            nxt_port = PORT_RING;
            nxt_esc  = 1'b1;
        end
    end

    // Output register: capture a decision only for a valid request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            port_q <= PORT_HOLD;
            esc_q  <= 1'b0;
            cnt_q  <= '0;
        end else begin
            vld_q <= req_vld_i;
            if (req_vld_i) begin
                port_q <= nxt_port;
                esc_q  <= nxt_esc;
                cnt_q  <= nxt_cnt;
            end
        end
    end

    assign sel_vld_o  = vld_q;
    assign sel_port_o = port_q;
    assign esc_o      = esc_q;
    assign mis_cnt_o  = cnt_q;
endmodule

// File: rtl/power_route_sel_chk.sv
// Property checker for the route selector, attached by bind.
module power_route_sel_chk #(
    parameter int CW    = 2,
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_vld_i,
    input logic [CW-1:0]    cur_x_i,
    input logic [CW-1:0]    cur_y_i,
    input logic [CW-1:0]    dst_x_i,
    input logic [CW-1:0]    dst_y_i,
    input logic             on_esc_i,
    input logic [CNT_W-1:0] mis_cnt_i,
    input logic             sel_vld_o,
    input logic [2:0]       sel_port_o,
    input logic             esc_o,
    input logic [CNT_W-1:0] mis_cnt_o
);
    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld_i |=> sel_vld_o);
    // R2
    vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld_i |=> !sel_vld_o);
    // R3
    eject_home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld_i && cur_x_i == dst_x_i && cur_y_i == dst_y_i)
        |=> sel_port_o == 3'd0);
    // R4
    stay_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld_i && on_esc_i && !(cur_x_i == dst_x_i && cur_y_i == dst_y_i))
        |=> (sel_port_o == 3'd5 && esc_o));
    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld_i |=> (mis_cnt_o == $past(mis_cnt_i)
                       || mis_cnt_o == CNT_W'($past(mis_cnt_i) + 1'b1)));
    // R7
    hold_adaptive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_vld_o && sel_port_o == 3'd6) |-> !esc_o);
    // R9
    ring_escape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_vld_o && sel_port_o == 3'd5) |-> esc_o);
    // R10
    idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld_i |=> ($stable(sel_port_o) && $stable(esc_o) && $stable(mis_cnt_o)));
endmodule

bind power_route_sel power_route_sel_chk #(.CW(CW), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_vld_i(req_vld_i),
    .cur_x_i(cur_x_i), .cur_y_i(cur_y_i), .dst_x_i(dst_x_i), .dst_y_i(dst_y_i),
    .on_esc_i(on_esc_i), .mis_cnt_i(mis_cnt_i),
    .sel_vld_o(sel_vld_o), .sel_port_o(sel_port_o), .esc_o(esc_o),
    .mis_cnt_o(mis_cnt_o)
);

// File: tb/power_route_sel_tb_top.sv
// Scoreboard bench: the driver queues model results, the monitor compares.
module power_route_sel_tb_top;
    typedef struct {
        logic [2:0] port;
        logic       esc;
        logic [2:0] cnt;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_vld_i = 1'b0;
    logic [1:0] cur_x_i = '0, cur_y_i = '0, dst_x_i = '0, dst_y_i = '0;
    logic [3:0] nbr_pwr_i = '0, out_free_i = '0;
    logic       on_esc_i = 1'b0;
    logic [2:0] mis_cnt_i = '0, mis_thr_i = '0;
    logic       sel_vld_o, esc_o;
    logic [2:0] sel_port_o, mis_cnt_o;

    int   total = 0;
    int   bad = 0;
    bit   mon_on = 1'b0;
    bit   have_last = 1'b0;
    exp_t last_e;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    power_route_sel dut_i (
        .clk(clk), .rst_n(rst_n), .req_vld_i(req_vld_i),
        .cur_x_i(cur_x_i), .cur_y_i(cur_y_i), .dst_x_i(dst_x_i), .dst_y_i(dst_y_i),
        .nbr_pwr_i(nbr_pwr_i), .out_free_i(out_free_i), .on_esc_i(on_esc_i),
        .mis_cnt_i(mis_cnt_i), .mis_thr_i(mis_thr_i),
        .sel_vld_o(sel_vld_o), .sel_port_o(sel_port_o), .esc_o(esc_o),
        .mis_cnt_o(mis_cnt_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model from the requirement list (port codes per R2).
    function automatic exp_t model(input int cx, input int cy, input int dx, input int dy,
                                   input logic [3:0] pwr, input logic [3:0] fr,
                                   input logic oe, input int cnt, input int thr);
        exp_t e;
        logic [3:0] prod, edge_ok;
        e.port = 3'd6; e.esc = 1'b0; e.cnt = 3'(cnt);
        prod    = {dy < cy, dy > cy, dx < cx, dx > cx};
        edge_ok = {cy > 0, cy < 3, cx > 0, cx < 3};
        if (cx == dx && cy == dy) begin
            e.port = 3'd0; e.esc = oe;
        end else if (oe || cnt >= thr) begin
            e.port = 3'd5; e.esc = 1'b1;
        end else if ((prod & pwr & fr) != 0) begin
            e.port = prod[0] && pwr[0] && fr[0] ? 3'd1 :
                     prod[1] && pwr[1] && fr[1] ? 3'd2 :
                     prod[2] && pwr[2] && fr[2] ? 3'd3 : 3'd4;
        end else if ((prod & pwr) != 0) begin
            e.port = 3'd6;
        end else begin
            e.port = 3'd5; e.esc = 1'b1;
            for (int d = 3; d >= 0; d--) begin
                if (!prod[d] && edge_ok[d] && pwr[d] && fr[d]) begin
                    e.port = 3'(d + 1); e.esc = 1'b0; e.cnt = 3'(cnt + 1);
                end
            end
        end
        return e;
    endfunction

    task automatic send(input string tag, input int cx, input int cy, input int dx,
                        input int dy, input logic [3:0] pwr, input logic [3:0] fr,
                        input logic oe, input int cnt, input int thr);
        exp_t e;
        @(negedge clk);
        cur_x_i = 2'(cx); cur_y_i = 2'(cy); dst_x_i = 2'(dx); dst_y_i = 2'(dy);
        nbr_pwr_i = pwr; out_free_i = fr; on_esc_i = oe;
        mis_cnt_i = 3'(cnt); mis_thr_i = 3'(thr); req_vld_i = 1'b1;
        e = model(cx, cy, dx, dy, pwr, fr, oe, cnt, thr);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Idle cycle with scrambled inputs (R10).
    task automatic idle_scramble();
        @(negedge clk);
        req_vld_i = 1'b0;
        cur_x_i = 2'd3; dst_x_i = 2'd0; on_esc_i = ~on_esc_i;
        mis_cnt_i = 3'd5; nbr_pwr_i = 4'hF; out_free_i = 4'hF;
    endtask

    // Monitor: one sample per cycle just after the rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (mon_on) begin
                if (sel_vld_o) begin
                    if (sb_q.size() == 0) begin
                        chk("R2 unexpected valid", 8'(sel_vld_o), 8'd0);
                    end else begin
                        exp_t e;
                        e = sb_q.pop_front();
                        chk({e.tag, " port"}, 8'(sel_port_o), 8'(e.port));
                        chk({e.tag, " esc"},  8'(esc_o),      8'(e.esc));
                        chk({e.tag, " cnt"},  8'(mis_cnt_o),  8'(e.cnt));
                        last_e = e; have_last = 1'b1;
                    end
                end else if (have_last) begin
                    chk("R10 idle port", 8'(sel_port_o), 8'(last_e.port));
                    chk("R10 idle cnt",  8'(mis_cnt_o),  8'(last_e.cnt));
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        repeat (20000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 vld",  8'(sel_vld_o),  8'd0);
        chk("R1 port", 8'(sel_port_o), 8'd6);
        chk("R1 esc",  8'(esc_o),      8'd0);
        chk("R1 cnt",  8'(mis_cnt_o),  8'd0);
        @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1'b1;
        // R3: arrival wins over escape, limit and dead neighbours
        send("R3 eject on ring", 2, 1, 2, 1, 4'h0, 4'h0, 1'b1, 7, 0);
        send("R3 eject adaptive", 0, 3, 0, 3, 4'hF, 4'hF, 1'b0, 2, 5);
        // R4: already on the ring
        send("R4 stay ring", 1, 1, 3, 3, 4'hF, 4'hF, 1'b1, 0, 7);
        // R5: limit reached although east is usable
        send("R5 limit", 1, 1, 3, 3, 4'hF, 4'hF, 1'b0, 3, 3);
        send("R5 zero limit", 1, 1, 3, 3, 4'hF, 4'hF, 1'b0, 0, 0);
        // R6: X before Y, then Y when X busy, then west
        send("R6 prefer x", 1, 1, 3, 3, 4'hF, 4'hF, 1'b0, 0, 4);
        send("R6 y when x busy", 1, 1, 3, 3, 4'hF, 4'b1110, 1'b0, 1, 4);
        send("R6 west", 2, 2, 0, 0, 4'hF, 4'hF, 1'b0, 0, 4);
        send("R6 south only", 2, 2, 2, 0, 4'hF, 4'hF, 1'b0, 0, 4);
        idle_scramble();
        idle_scramble();
        // R7: productive neighbours on but busy
        send("R7 hold", 1, 1, 3, 3, 4'hF, 4'b0000, 1'b0, 2, 4);
        // R8: east off, detour picks west, then north when west off
        send("R8 detour west", 1, 1, 3, 1, 4'b1110, 4'hF, 1'b0, 0, 4);
        send("R8 detour north", 1, 1, 3, 1, 4'b1100, 4'hF, 1'b0, 6, 7);
        send("R8 edge skip", 3, 0, 3, 3, 4'b0011, 4'hF, 1'b0, 1, 4);
        send("R8 corner", 0, 0, 3, 0, 4'b0100, 4'hF, 1'b0, 2, 4);
        // R9: no detour possible at the edge
        send("R9 no detour", 3, 0, 3, 3, 4'b0001, 4'hF, 1'b0, 1, 4);
        send("R9 busy detour", 1, 1, 3, 1, 4'b1110, 4'b0001, 1'b0, 0, 4);
        idle_scramble();
        repeat (4) @(negedge clk);
        chk("R2 scoreboard drained", 8'(sb_q.size()), 8'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule